// File: doc/BRIEF.md
# List-Driven Block Copy Engine

This engine executes one copy command at a time between a local word-addressed memory and a remote memory. Each command is either a *get*, which reads the remote side and writes the local side, or a *put*, which moves data the other way. A single-block command names the local address, the remote address and a byte count directly.

A list command instead points at a table of block descriptors held in local memory. The engine fetches each descriptor in turn and copies that block. The local address runs on contiguously from one block to the next. When the last word of the whole command has been written, a one-cycle completion pulse is raised. Malformed commands are refused: they complete at once with an error flag and move no data.

Both memory ports are simple word ports with a combinational read path and a ready input. A word crosses the engine in every cycle in which both ports are ready.

Top module: `blk_copy_engine`

## Requirements
- R1: `cmdReady` is high only while the engine is idle. A command is taken on a clock edge where `cmdValid` and `cmdReady` are both high. From the next cycle `cmdReady` stays low up to and including the completion cycle, and it is high again in the cycle after that.
- R2: A single get (`cmdPut`=0, `cmdList`=0) copies `cmdSize`/4 words. It reads them from remote byte address `cmdRmtAddr` upward and writes them to local byte address `cmdLclAddr` upward, at consecutive word addresses.
- R3: A single put (`cmdPut`=1, `cmdList`=0) copies `cmdSize`/4 words from local `cmdLclAddr` upward to remote `cmdRmtAddr` upward.
- R4: With both readies held high, a valid single command of N words raises `doneValid` exactly N+1 clock edges after the accepting edge. A valid list command takes the sum over its elements of (2 + words in the element), plus 1.
- R5: In a cycle where either ready is low, no word moves. A write enable is asserted only in cycles where both readies are high. Any stall pattern still yields the same memory contents.
- R6: For a list command (`cmdList`=1), `cmdRmtAddr` is the local byte address of the descriptor table and `cmdSize` is the element count. Element i occupies two words at table address + 8i: first the remote byte address, then the byte size. The direction comes from `cmdPut`. The local address continues contiguously from `cmdLclAddr` across elements.
- R7: A single command whose size is 0, is greater than 16384, or is not a multiple of 4 is refused. `doneValid` with `doneErr`=1 appears one edge after acceptance, and no memory is written.
- R8: A list command whose element count is below 2 or above 2048 is refused in the same way as R7. A count of exactly 2048 is executed.
- R9: If a list element's size is invalid by the R7 rules, the command stops at that element with `doneErr`=1. Blocks of earlier elements stay copied, and nothing of that element or later elements is written.
- R10: `doneValid` is a single-cycle pulse, one per accepted command. `doneErr` is 0 for a command that completed normally.
- R11: After reset, `cmdReady`=1, `doneValid`=0 and no memory write enable is active.
- R12: A 16384-byte block (4096 words) is accepted and copied completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine idle and able to take a command |
| cmdPut | input | 1 | 1 = local to remote, 0 = remote to local |
| cmdList | input | 1 | 1 = descriptor list command |
| cmdLclAddr | input | AW | Local start byte address |
| cmdRmtAddr | input | AW | Remote byte address, or table address for a list |
| cmdSize | input | SW | Byte size, or element count for a list |
| lclAddr | output | AW | Local port byte address |
| lclRdEn | output | 1 | Local read request |
| lclWrEn | output | 1 | Local write strobe |
| lclWdata | output | 32 | Local write data |
| lclRdata | input | 32 | Local read data (same cycle) |
| lclReady | input | 1 | Local port can serve this cycle |
| rmtAddr | output | AW | Remote port byte address |
| rmtRdEn | output | 1 | Remote read request |
| rmtWrEn | output | 1 | Remote write strobe |
| rmtWdata | output | 32 | Remote write data |
| rmtRdata | input | 32 | Remote read data (same cycle) |
| rmtReady | input | 1 | Remote port can serve this cycle |
| doneValid | output | 1 | Command completion pulse |
| doneErr | output | 1 | Completion was a refusal or an element abort |

## Verification
A corrupted word counter or address pointer shows up at the ports within the command itself. The completion edge lands on the wrong cycle, so R4's exact latency checks catch it on that command. Wrong destination words are found by comparing the memories after each command. A descriptor fetched from the wrong table slot sends data to an unexpected remote region, and that surfaces in the same comparison. A stuck error flag or a lost state transition appears as a wrong `doneErr` value or a missing pulse. The scoreboard flags either one on the first affected command.

// File: rtl/bce_pkg.sv
package bce_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET_ADDR,
    ST_GET_SIZE,
    ST_MOVE,
    ST_FINISH
  } bceState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic fetchAddr;
    logic fetchSize;
    logic takeAddr;
    logic takeSize;
    logic moving;
    logic stepWord;
    logic stepElem;
  } bceStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lastWord;
    logic moreElems;
    logic elemSizeOk;
  } bceStatus_t;

  function automatic logic blkSizeOk(input logic [31:0] sz, input int unsigned maxBytes);
    return (sz != 32'd0) && (sz <= maxBytes) && (sz[1:0] == 2'b00);
  endfunction

endpackage

// File: rtl/bce_ctrl.sv
module bce_ctrl
  import bce_pkg::*;
#(
  parameter int unsigned SW            = 16,
  parameter int unsigned MAX_BLK_BYTES = 16384,
  parameter int unsigned MIN_LIST      = 2,
  parameter int unsigned MAX_LIST      = 2048
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic          cmdList,
  input  logic [SW-1:0] cmdSize,
  output logic          cmdReady,
  input  logic          lclReady,
  input  logic          rmtReady,
  input  bceStatus_t    stat,
  output bceStrobe_t    strobe,
  output logic          doneValid,
  output logic          doneErr
);

  bceState_t state, stateNext;
  logic errReg, errNext;
  logic cmdOk;

  always_comb begin
    if (cmdList)
      cmdOk = (32'(cmdSize) >= MIN_LIST) && (32'(cmdSize) <= MAX_LIST);
    else
      cmdOk = blkSizeOk(32'(cmdSize), MAX_BLK_BYTES);
  end

  always_comb begin
    stateNext = state;
    errNext   = errReg;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          strobe.loadCmd = cmdOk;
          errNext        = !cmdOk;
          if (!cmdOk)       stateNext = ST_FINISH;
          else if (cmdList) stateNext = ST_GET_ADDR;
          else              stateNext = ST_MOVE;
        end
      end
      ST_GET_ADDR: begin
        strobe.fetchAddr = 1'b1;
        if (lclReady) begin
          strobe.takeAddr = 1'b1;
          stateNext       = ST_GET_SIZE;
        end
      end
      ST_GET_SIZE: begin
        strobe.fetchSize = 1'b1;
        if (lclReady) begin
          if (stat.elemSizeOk) begin
            strobe.takeSize = 1'b1;
            stateNext       = ST_MOVE;
          end else begin
            errNext   = 1'b1;
            stateNext = ST_FINISH;
          end
        end
      end
      ST_MOVE: begin
        strobe.moving = 1'b1;
        if (lclReady && rmtReady) begin
          strobe.stepWord = 1'b1;
          if (stat.lastWord) begin
            if (stat.moreElems) begin
              strobe.stepElem = 1'b1;
              stateNext       = ST_GET_ADDR;
            end else begin
              stateNext = ST_FINISH;
            end
          end
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      errReg <= 1'b0;
    end else begin
      state  <= stateNext;
      errReg <= errNext;
    end
  end

  assign cmdReady  = (state == ST_IDLE);
  assign doneValid = (state == ST_FINISH);
  assign doneErr   = doneValid && errReg;

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady); // R1
  AST_ZERO_SIZE_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && !cmdList && cmdSize == '0) |=> (doneValid && doneErr)); // R7
  AST_LIST_ONE_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdList && cmdSize == SW'(1)) |=> (doneValid && doneErr)); // R8

endmodule

// File: rtl/bce_dpath.sv
module bce_dpath
  import bce_pkg::*;
#(
  parameter int unsigned AW            = 32,
  parameter int unsigned SW            = 16,
  parameter int unsigned MAX_BLK_BYTES = 16384,
  parameter int unsigned MAX_LIST      = 2048
) (
  input  logic          clk,
  input  logic          rstN,
  input  bceStrobe_t    strobe,
  output bceStatus_t    stat,
  input  logic          cmdPut,
  input  logic          cmdList,
  input  logic [AW-1:0] cmdLclAddr,
  input  logic [AW-1:0] cmdRmtAddr,
  input  logic [SW-1:0] cmdSize,
  output logic [AW-1:0] lclAddr,
  output logic          lclRdEn,
  output logic          lclWrEn,
  output logic [31:0]   lclWdata,
  input  logic [31:0]   lclRdata,
  output logic [AW-1:0] rmtAddr,
  output logic          rmtRdEn,
  output logic          rmtWrEn,
  output logic [31:0]   rmtWdata,
  input  logic [31:0]   rmtRdata
);

  localparam int unsigned REM_W = $clog2(MAX_BLK_BYTES + 1);
  localparam int unsigned LEN_W = $clog2(MAX_LIST + 1);

  logic             putDir, isList;
  logic [AW-1:0]    lclPtr, rmtPtr, tblPtr;
  logic [REM_W-1:0] remain;
  logic [LEN_W-1:0] elemLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      putDir   <= 1'b0;
      isList   <= 1'b0;
      lclPtr   <= '0;
      rmtPtr   <= '0;
      tblPtr   <= '0;
      remain   <= '0;
      elemLeft <= '0;
    end else begin
      if (strobe.loadCmd) begin
        putDir <= cmdPut;
        isList <= cmdList;
        lclPtr <= cmdLclAddr;
        if (cmdList) begin
          tblPtr   <= cmdRmtAddr;
          elemLeft <= cmdSize[LEN_W-1:0];
        end else begin
          rmtPtr   <= cmdRmtAddr;
          remain   <= cmdSize[REM_W-1:0];
          elemLeft <= '0;
        end
      end
      if (strobe.takeAddr) rmtPtr <= lclRdata[AW-1:0];
      if (strobe.takeSize) remain <= lclRdata[REM_W-1:0];
      if (strobe.stepWord) begin
        lclPtr <= lclPtr + AW'(4);
        rmtPtr <= rmtPtr + AW'(4);
        remain <= remain - REM_W'(4);
      end
      if (strobe.stepElem) begin
        tblPtr   <= tblPtr + AW'(8);
        elemLeft <= elemLeft - LEN_W'(1);
      end
    end
  end

  assign stat.lastWord   = (remain == REM_W'(4));
  assign stat.moreElems  = isList && (elemLeft > LEN_W'(1));
  assign stat.elemSizeOk = blkSizeOk(lclRdata, MAX_BLK_BYTES);

  always_comb begin
    if (strobe.fetchAddr)      lclAddr = tblPtr;
    else if (strobe.fetchSize) lclAddr = tblPtr + AW'(4);
    else                       lclAddr = lclPtr;
  end

  assign lclRdEn  = strobe.fetchAddr || strobe.fetchSize || (strobe.moving && putDir);
  assign lclWrEn  = strobe.stepWord && !putDir;
  assign lclWdata = rmtRdata;
  assign rmtAddr  = rmtPtr;
  assign rmtRdEn  = strobe.moving && !putDir;
  assign rmtWrEn  = strobe.stepWord && putDir;
  assign rmtWdata = lclRdata;

  AST_MOVE_HAS_WORDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.moving |-> (remain != '0)); // R2
  AST_LOCAL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepWord |=> (lclPtr == $past(lclPtr) + AW'(4))); // R6
  AST_LIST_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    isList |-> (elemLeft <= LEN_W'(MAX_LIST))); // R8

endmodule

// File: rtl/blk_copy_engine.sv
module blk_copy_engine
  import bce_pkg::*;
#(
  parameter int unsigned AW            = 32,
  parameter int unsigned SW            = 16,
  parameter int unsigned MAX_BLK_BYTES = 16384,
  parameter int unsigned MIN_LIST      = 2,
  parameter int unsigned MAX_LIST      = 2048
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  output logic          cmdReady,
  input  logic          cmdPut,
  input  logic          cmdList,
  input  logic [AW-1:0] cmdLclAddr,
  input  logic [AW-1:0] cmdRmtAddr,
  input  logic [SW-1:0] cmdSize,
  output logic [AW-1:0] lclAddr,
  output logic          lclRdEn,
  output logic          lclWrEn,
  output logic [31:0]   lclWdata,
  input  logic [31:0]   lclRdata,
  input  logic          lclReady,
  output logic [AW-1:0] rmtAddr,
  output logic          rmtRdEn,
  output logic          rmtWrEn,
  output logic [31:0]   rmtWdata,
  input  logic [31:0]   rmtRdata,
  input  logic          rmtReady,
  output logic          doneValid,
  output logic          doneErr
);

  bceStrobe_t strobe;
  bceStatus_t stat;

  bce_ctrl #(
    .SW(SW), .MAX_BLK_BYTES(MAX_BLK_BYTES), .MIN_LIST(MIN_LIST), .MAX_LIST(MAX_LIST)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdList(cmdList), .cmdSize(cmdSize),
    .cmdReady(cmdReady), .lclReady(lclReady), .rmtReady(rmtReady), .stat(stat),
    .strobe(strobe), .doneValid(doneValid), .doneErr(doneErr)
  );

  bce_dpath #(
    .AW(AW), .SW(SW), .MAX_BLK_BYTES(MAX_BLK_BYTES), .MAX_LIST(MAX_LIST)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stat(stat), .cmdPut(cmdPut),
    .cmdList(cmdList), .cmdLclAddr(cmdLclAddr), .cmdRmtAddr(cmdRmtAddr), .cmdSize(cmdSize),
    .lclAddr(lclAddr), .lclRdEn(lclRdEn), .lclWrEn(lclWrEn), .lclWdata(lclWdata),
    .lclRdata(lclRdata), .rmtAddr(rmtAddr), .rmtRdEn(rmtRdEn), .rmtWrEn(rmtWrEn),
    .rmtWdata(rmtWdata), .rmtRdata(rmtRdata)
  );

  AST_WRITE_BOTH_READY: assert property (@(posedge clk) disable iff (!rstN)
    (lclWrEn || rmtWrEn) |-> (lclReady && rmtReady)); // R5
  AST_ONE_WRITE_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    !(lclWrEn && rmtWrEn)); // R3

endmodule

// File: tb/sim_blk_copy_engine.sv
module sim_blk_copy_engine;

  localparam int MW = 8192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        cmdValid = 1'b0, cmdPut = 1'b0, cmdList = 1'b0;
  logic [31:0] cmdLclAddr = '0, cmdRmtAddr = '0;
  logic [15:0] cmdSize = '0;
  logic        cmdReady;
  logic [31:0] lclAddr, lclWdata, lclRdata, rmtAddr, rmtWdata, rmtRdata;
  logic        lclRdEn, lclWrEn, rmtRdEn, rmtWrEn, doneValid, doneErr;
  logic        lclReady, rmtReady;

  logic [31:0] lmem [MW];
  logic [31:0] rmem [MW];
  logic        tbLwe = 1'b0, tbRwe = 1'b0;
  logic [12:0] tbIdx = '0;
  logic [31:0] tbDat = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic        stallMode = 1'b0;
  int          cyc = 0;

  assign lclRdata = lmem[lclAddr[14:2]];
  assign rmtRdata = rmem[rmtAddr[14:2]];
  assign lclReady = stallMode ? (lfsr[0] | lfsr[5]) : 1'b1;
  assign rmtReady = stallMode ? (lfsr[3] | lfsr[9]) : 1'b1;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (tbLwe) lmem[tbIdx] <= tbDat;
    else if (lclWrEn) lmem[lclAddr[14:2]] <= lclWdata;
    if (tbRwe) rmem[tbIdx] <= tbDat;
    else if (rmtWrEn) rmem[rmtAddr[14:2]] <= rmtWdata;
  end

  blk_copy_engine u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdPut(cmdPut),
    .cmdList(cmdList), .cmdLclAddr(cmdLclAddr), .cmdRmtAddr(cmdRmtAddr), .cmdSize(cmdSize),
    .lclAddr(lclAddr), .lclRdEn(lclRdEn), .lclWrEn(lclWrEn), .lclWdata(lclWdata),
    .lclRdata(lclRdata), .lclReady(lclReady), .rmtAddr(rmtAddr), .rmtRdEn(rmtRdEn),
    .rmtWrEn(rmtWrEn), .rmtWdata(rmtWdata), .rmtRdata(rmtRdata), .rmtReady(rmtReady),
    .doneValid(doneValid), .doneErr(doneErr)
  );

  typedef struct { bit err; int lat; int acc; string req; } expItem_t;
  expItem_t expQ [$];
  int nChk = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(logic [31:0] seed, int k);
    return seed ^ (32'(k) * 32'h0100_0193);
  endfunction

  task automatic wrWord(bit toLcl, int w, logic [31:0] v);
    tbIdx = 13'(w); tbDat = v; tbLwe = toLcl; tbRwe = !toLcl;
    @(negedge clk);
    tbLwe = 1'b0; tbRwe = 1'b0;
  endtask

  task automatic fill(bit toLcl, int w, int n, logic [31:0] seed);
    for (int k = 0; k < n; k++) wrWord(toLcl, w + k, pat(seed, w + k));
  endtask

  // monitor: pops the scoreboard on each completion
  bit prevDone = 0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (prevDone && doneValid) chk(0, "R10", "done wider than one cycle", 1, 0);
      if (doneValid) begin
        if (expQ.size() == 0) chk(0, "R10", "unexpected completion", 1, 0);
        else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(doneErr == e.err, e.req, "doneErr", doneErr, e.err);
          if (e.lat >= 0) chk(cyc - e.acc == e.lat, e.req, "completion latency", cyc - e.acc, e.lat);
          chk(cmdReady == 1'b0, "R1", "ready during completion", cmdReady, 0);
        end
      end
      prevDone <= doneValid;
    end
  end

  task automatic send(bit put, bit lst, int lcl, int rmt, int size, bit err, int lat, string req);
    expItem_t e;
    cmdPut = put; cmdList = lst; cmdLclAddr = 32'(lcl); cmdRmtAddr = 32'(rmt);
    cmdSize = 16'(size); cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(posedge clk);
    e.err = err; e.lat = lat; e.acc = cyc; e.req = req;
    expQ.push_back(e);
    @(negedge clk);
    cmdValid = 1'b0;
    chk(cmdReady == 1'b0, "R1", "ready after accept", cmdReady, 0);
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(cmdReady == 1'b1, "R1", "ready after completion", cmdReady, 1);
  endtask

  task automatic cmpMem(bit dstL, int dw, bit srcL, int sw, int n, string req, string what);
    int bad = 0;
    logic [31:0] a = '0, b = '0;
    for (int k = 0; k < n; k++) begin
      a = dstL ? lmem[dw + k] : rmem[dw + k];
      b = srcL ? lmem[sw + k] : rmem[sw + k];
      if (a !== b) bad++;
    end
    chk(bad == 0, req, what, bad, 0);
  endtask

  task automatic cmpPat(bit inL, int w, int n, logic [31:0] seed, string req, string what);
    int bad = 0;
    for (int k = 0; k < n; k++)
      if ((inL ? lmem[w + k] : rmem[w + k]) !== pat(seed, w + k)) bad++;
    chk(bad == 0, req, what, bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmdReady == 1'b1, "R11", "cmdReady in reset", cmdReady, 1);
    chk(doneValid == 1'b0 && !lclWrEn && !rmtWrEn, "R11", "outputs idle in reset", doneValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    fill(0, 0, 1024, 32'h5A00_0000);
    fill(1, 2048, 16, 32'hDEAD_0000);
    send(0, 0, 32'h2000, 32'h100, 64, 0, 17, "R4");
    cmpMem(1, 2048, 0, 64, 16, "R2", "single get data");

    fill(1, 192, 10, 32'h1234_0000);
    send(1, 0, 32'h300, 32'h1000, 40, 0, 11, "R4");
    cmpMem(0, 1024, 1, 192, 10, "R3", "single put data");

    stallMode = 1'b1;
    send(0, 0, 32'h2200, 32'h200, 128, 0, -1, "R5");
    cmpMem(1, 2176, 0, 128, 32, "R5", "stalled get data");
    stallMode = 1'b0;

    fill(1, 2560, 8, 32'hBEEF_0000);
    send(0, 0, 32'h2800, 32'h0, 0, 1, 1, "R7");
    send(0, 0, 32'h2800, 32'h0, 6, 1, 1, "R7");
    send(0, 0, 32'h2800, 32'h0, 16388, 1, 1, "R7");
    cmpPat(1, 2560, 8, 32'hBEEF_0000, "R7", "refused single wrote memory");

    wrWord(1, 64, 32'h400); wrWord(1, 65, 8);
    wrWord(1, 66, 32'h800); wrWord(1, 67, 12);
    wrWord(1, 68, 32'h40);  wrWord(1, 69, 4);
    send(0, 1, 32'h2800, 32'h100, 1, 1, 1, "R8");
    send(0, 1, 32'h2800, 32'h100, 2049, 1, 1, "R8");
    cmpPat(1, 2560, 8, 32'hBEEF_0000, "R8", "refused list wrote memory");

    send(0, 1, 32'h1000, 32'h100, 3, 0, 13, "R4");
    cmpMem(1, 1024, 0, 256, 2, "R6", "list element 0");
    cmpMem(1, 1026, 0, 512, 3, "R6", "list element 1");
    cmpMem(1, 1029, 0, 16, 1, "R6", "list element 2");

    fill(1, 1536, 6, 32'h7777_0000);
    wrWord(1, 200, 32'h3000); wrWord(1, 201, 16);
    wrWord(1, 202, 32'h3400); wrWord(1, 203, 8);
    stallMode = 1'b1;
    send(1, 1, 32'h1800, 32'h320, 2, 0, -1, "R6");
    stallMode = 1'b0;
    cmpMem(0, 3072, 1, 1536, 4, "R6", "list put element 0");
    cmpMem(0, 3328, 1, 1540, 2, "R6", "list put element 1");

    fill(1, 2304, 6, 32'hC0DE_0000);
    wrWord(1, 300, 32'h400); wrWord(1, 301, 8);
    wrWord(1, 302, 32'h500); wrWord(1, 303, 0);
    wrWord(1, 304, 32'h600); wrWord(1, 305, 8);
    send(0, 1, 32'h2400, 32'h4B0, 3, 1, 7, "R9");
    cmpMem(1, 2304, 0, 256, 2, "R9", "element before abort");
    cmpPat(1, 2306, 4, 32'hC0DE_0000, "R9", "written after abort");

    fill(0, 0, 4096, 32'h3C00_0000);
    send(0, 0, 32'h4000, 32'h0, 16384, 0, 4097, "R12");
    cmpMem(1, 4096, 0, 0, 4096, "R12", "maximum block data");

    fill(0, 4096, 2048, 32'h6600_0000);
    for (int i = 0; i < 2048; i++) begin
      wrWord(1, 2 * i, 32'((4096 + i) * 4));
      wrWord(1, 2 * i + 1, 4);
    end
    send(0, 1, 32'h4000, 32'h0, 2048, 0, 6145, "R8");
    cmpMem(1, 4096, 0, 4096, 2048, "R8", "longest list data");

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++; nFail++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule